// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This controller sits on the host side of a parallel flash device and decides when an embedded program or erase operation has finished. A one-cycle `start` pulse launches polling. The controller then reads the device's status byte over a simple request/acknowledge port, one read at a time. It compares the toggle bit (bit 6) across two back-to-back reads. Equal values mean the operation is complete. When the values differ, bit 5 (the exceeded-timing flag) of the second read decides the next step. If it is low, polling continues. If it is high, one more confirming pair is read, because the toggle bit may have stopped just as bit 5 rose.

The result is a one-cycle `done_ok` or `done_fail` pulse. The byte from the last read is held on `last_status`. When `EN_ERASE_FLAG` is set, the controller also compares bit 2 across the pair that produced the verdict. It raises `erase_sel` if that bit toggled, which means the polled address lies in a sector selected for erase. A loop cap, `MAX_LOOPS`, forces a failure if the toggle bit never settles and bit 5 never rises.

The state machine has eight states:
- `ST_IDLE`: waiting for `start`.
- `ST_RD_A`: first read of a pair.
- `ST_RD_B`: second read of a pair.
- `ST_JUDGE`: compares the pair, looks at bit 5 and checks the loop cap.
- `ST_CONF_A` and `ST_CONF_B`: the confirming pair.
- `ST_PASS` and `ST_FAIL`: one-cycle result states.

The transitions are:
- idle→rd_a on `start`.
- rd_a→rd_b and rd_b→judge on acknowledge.
- judge→pass when the toggle bits match.
- judge→conf_a when they differ and bit 5 is high.
- judge→rd_a when they differ, bit 5 is low and the cap is not reached.
- judge→fail when they differ, bit 5 is low and the cap is reached.
- conf_a→conf_b on acknowledge.
- conf_b→pass or conf_b→fail on acknowledge, depending on the comparison.
- pass→idle and fail→idle unconditionally.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset the controller is idle: `rd_req`, `busy`, `done_ok` and `done_fail` are all low.
- R2: A `start` pulse in idle begins polling. Exactly one read is outstanding at a time. `rd_req` stays high until the cycle in which `rd_ack` is seen, and the byte on `rd_data` is taken in that same cycle.
- R3: If bit 6 is equal in the two reads of a pair, `done_ok` pulses.
- R4: If bit 6 differs and bit 5 of the second read is 0, another pair of reads follows.
- R5: If bit 6 differs and bit 5 of the second read is 1, a confirming pair is read. A match in that pair gives `done_ok`; a mismatch gives `done_fail`.
- R6: If `MAX_LOOPS` ordinary pairs all end in a bit-6 mismatch with bit 5 low, `done_fail` pulses after the last of them, with no further reads.
- R7: `last_status` holds the byte from the most recent acknowledged read. At a done pulse this is the last byte of the verdict pair.
- R8: With `EN_ERASE_FLAG`=1, `erase_sel` at the done pulse is 1 exactly when bit 2 differed in the pair that produced the verdict. With `EN_ERASE_FLAG`=0 it is 0.
- R9: `start` is ignored while `busy` is high; it causes no extra reads.
- R10: Each done output is a single-cycle pulse. The cycle after it, the controller is idle with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling (honoured only when idle) |
| rd_req | output | 1 | Status read request, held until acknowledged |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid in this cycle |
| rd_data | input | 8 | Status byte returned by the flash |
| busy | output | 1 | High from the first read until the done pulse inclusive |
| done_ok | output | 1 | One-cycle pulse: operation completed |
| done_fail | output | 1 | One-cycle pulse: operation failed or loop cap hit |
| last_status | output | 8 | Byte from the most recent acknowledged read |
| erase_sel | output | 1 | Bit 2 toggled in the verdict pair (optional mode) |

## Verification
The embedded assertions assume that the flash side raises `rd_ack` only while `rd_req` is high, for a single cycle per read. They also assume that `start` is a level sampled on clock edges, with no other constraint. The bench's flash model drives acknowledge only after it has seen the request. It drops acknowledge the cycle after raising it and waits a configurable latency of zero or two cycles. It also holds `start` high for whole stretches of a busy run, to exercise R9 within those bounds.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_JUDGE,
        ST_CONF_A,
        ST_CONF_B,
        ST_PASS,
        ST_FAIL
    } tpc_state_e;

    localparam int unsigned TGL_BIT   = 6;
    localparam int unsigned TMO_BIT   = 5;
    localparam int unsigned ERASE_BIT = 2;
endpackage

// File: rtl/tpc_bit_cmp.sv
module tpc_bit_cmp #(
    parameter int unsigned DW            = 8,
    parameter bit          EN_ERASE_FLAG = 1'b1
) (
    input  logic [DW-1:0] first_b,
    input  logic [DW-1:0] second_b,
    output logic          tgl_diff,
    output logic          tmo_set,
    output logic          ers_diff
);
    import tpc_pkg::*;

    assign tgl_diff = first_b[TGL_BIT] ^ second_b[TGL_BIT];
    assign tmo_set  = second_b[TMO_BIT];

    generate
        if (EN_ERASE_FLAG) begin : g_ers
            assign ers_diff = first_b[ERASE_BIT] ^ second_b[ERASE_BIT];
        end else begin : g_no_ers
            assign ers_diff = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/tpc_loop_cnt.sv
module tpc_loop_cnt #(
    parameter int unsigned MAX_LOOPS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_cap
);
    localparam int unsigned CW = $clog2(MAX_LOOPS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    assign at_cap = (cnt_q == CW'(MAX_LOOPS - 1));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(MAX_LOOPS));
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
    parameter int unsigned MAX_LOOPS     = 64,
    parameter bit          EN_ERASE_FLAG = 1'b1,
    parameter int unsigned DW            = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          rd_req,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done_ok,
    output logic          done_fail,
    output logic [DW-1:0] last_status,
    output logic          erase_sel
);
    import tpc_pkg::*;

    tpc_state_e state_q, state_d;

    logic [DW-1:0] first_q, second_q;
    logic [DW-1:0] cmp_b;
    logic          tgl_diff, tmo_set, ers_diff;
    logic          at_cap, loop_inc, loop_clr;
    logic          ers_q;

    // In the last confirming read, compare against the live acknowledged byte.
    assign cmp_b = (state_q == ST_CONF_B) ? rd_data : second_q;

    tpc_bit_cmp #(.DW(DW), .EN_ERASE_FLAG(EN_ERASE_FLAG)) u_cmp (
        .first_b  (first_q),
        .second_b (cmp_b),
        .tgl_diff (tgl_diff),
        .tmo_set  (tmo_set),
        .ers_diff (ers_diff)
    );

    assign loop_clr = (state_q == ST_IDLE) && start;
    assign loop_inc = (state_q == ST_JUDGE) && tgl_diff && !tmo_set && !at_cap;

    tpc_loop_cnt #(.MAX_LOOPS(MAX_LOOPS)) u_loop (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (loop_clr),
        .inc    (loop_inc),
        .at_cap (at_cap)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_RD_A;
            ST_RD_A:   if (rd_ack) state_d = ST_RD_B;
            ST_RD_B:   if (rd_ack) state_d = ST_JUDGE;
            ST_JUDGE: begin
                if (!tgl_diff)    state_d = ST_PASS;
                else if (tmo_set) state_d = ST_CONF_A;
                else if (at_cap)  state_d = ST_FAIL;
                else              state_d = ST_RD_A;
            end
            ST_CONF_A: if (rd_ack) state_d = ST_CONF_B;
            ST_CONF_B: if (rd_ack) state_d = tgl_diff ? ST_FAIL : ST_PASS;
            ST_PASS:   state_d = ST_IDLE;
            ST_FAIL:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q     <= '0;
            second_q    <= '0;
            last_status <= '0;
            ers_q       <= 1'b0;
        end else begin
            if (rd_ack && (state_q == ST_RD_A || state_q == ST_CONF_A)) first_q  <= rd_data;
            if (rd_ack && state_q == ST_RD_B)                            second_q <= rd_data;
            if (rd_ack && rd_req)                                        last_status <= rd_data;
            if (loop_clr)
                ers_q <= 1'b0;
            else if ((state_q == ST_JUDGE && (state_d == ST_PASS || state_d == ST_FAIL)) ||
                     (state_q == ST_CONF_B && rd_ack))
                ers_q <= ers_diff;
        end
    end

    // outputs
    always_comb begin
        rd_req    = 1'b0;
        busy      = 1'b1;
        done_ok   = 1'b0;
        done_fail = 1'b0;
        unique case (state_q)
            ST_IDLE:                                  busy = 1'b0;
            ST_RD_A, ST_RD_B, ST_CONF_A, ST_CONF_B:   rd_req = 1'b1;
            ST_JUDGE:                                 ;
            ST_PASS:                                  done_ok = 1'b1;
            ST_FAIL:                                  done_fail = 1'b1;
            default:                                  busy = 1'b0;
        endcase
    end

    assign erase_sel = ers_q;

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req);

    // R7
    status_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ack |=> $stable(last_status));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok || done_fail) |=> (!done_ok && !done_fail && !busy));

    // R9
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R3
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok && done_fail));
endmodule

// File: tb/toggle_poll_ctrl_test.sv
module toggle_poll_ctrl_test;
    localparam int unsigned MAXL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       rd_req, rd_ack = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       busy, done_ok, done_fail, erase_sel;
    logic [7:0] last_status;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    toggle_poll_ctrl #(.MAX_LOOPS(MAXL), .EN_ERASE_FLAG(1'b1), .DW(8)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_ack(rd_ack),
        .rd_data(rd_data), .busy(busy), .done_ok(done_ok), .done_fail(done_fail),
        .last_status(last_status), .erase_sel(erase_sel)
    );

    // flash status model: bit6 toggles for the first tstop reads, then freezes;
    // bit5 rises at read index t5; bit2 toggles every read when erasing.
    function automatic logic [7:0] stat_byte(int i, int tstop, int t5, bit ers);
        int  k = (i < tstop) ? i : tstop;
        logic b6 = k[0];
        logic b5 = (i >= t5);
        logic b2 = ers ? i[0] : 1'b0;
        return {1'b0, b6, b5, 2'b00, b2, i[1:0]};
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected outcome, derived from the polling rules
    task automatic predict(int tstop, int t5, bit ers,
                           output bit ok, output int nreads, output logic [7:0] last, output bit ef);
        int  idx = 0;
        int  loops = 0;
        logic [7:0] a, b;
        forever begin
            a = stat_byte(idx, tstop, t5, ers);
            b = stat_byte(idx + 1, tstop, t5, ers);
            idx += 2;
            if (a[6] == b[6]) begin ok = 1; break; end
            if (b[5]) begin
                a = stat_byte(idx, tstop, t5, ers);
                b = stat_byte(idx + 1, tstop, t5, ers);
                idx += 2;
                ok = (a[6] == b[6]);
                break;
            end
            if (loops == MAXL - 1) begin ok = 0; break; end
            loops++;
        end
        nreads = idx;
        last = b;
        ef = a[2] ^ b[2];
    endtask

    task automatic run(int tstop, int t5, bit ers, int lat, bit hammer);
        bit ok_e, ef_e;
        int nr_e;
        logic [7:0] last_e;
        int idx = 0;
        int w = 0;
        int cyc = 0;
        bit seen = 0;
        predict(tstop, t5, ers, ok_e, nr_e, last_e, ef_e);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = hammer;
        while (!seen) begin
            if (rd_ack) begin
                rd_ack = 1'b0;
                idx++;
                w = 0;
            end else if (rd_req) begin
                if (w == lat) begin
                    rd_data = stat_byte(idx, tstop, t5, ers);
                    rd_ack = 1'b1;
                end else w++;
            end
            @(negedge clk);
            cyc++;
            if (done_ok || done_fail) begin
                seen = 1;
                start = 1'b0;
                // R3 R5 R6
                check(ok_e ? "R3/R5 done_ok" : "R5/R6 done_fail", {done_ok, done_fail}, ok_e ? 2 : 1);
                // R2 R4 R9
                check("R2/R4/R9 read count", idx + (rd_ack ? 1 : 0), nr_e);
                // R7
                check("R7 last_status", last_status, last_e);
                // R8
                check("R8 erase_sel", erase_sel, ef_e);
            end
            if (cyc > 2000) begin
                check("watchdog", 0, 1);
                seen = 1;
            end
        end
        rd_ack = 1'b0;
        @(negedge clk);
        // R10
        check("R10 idle after pulse", {busy, done_ok, done_fail, rd_req}, 0);
    endtask

    initial begin
        #12;
        @(negedge clk);
        // R1
        check("R1 reset outputs", {rd_req, busy, done_ok, done_fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", {rd_req, busy}, 0);
        for (int ts = 0; ts <= 12; ts++)
            for (int fi = 0; fi < 4; fi++)
                for (int e = 0; e < 2; e++)
                    for (int l = 0; l < 2; l++) begin
                        int t5 = (fi == 0) ? 0 : (fi == 1) ? 3 : (fi == 2) ? 6 : 100;
                        run(ts, t5, e[0], l * 2, ts[0]);
                    end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #900000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule